// File: doc/BRIEF.md
# PLL Out-of-Lock Run-Length Monitor

This block watches the correction flag that a phase-locked loop raises whenever it has to adjust its output to stay synchronized. The flag is sampled on every clock of the sample domain. The block counts how many active samples arrive back to back. If that run grows longer than a programmable threshold, the block records an out-of-lock condition.

Only unbroken runs count. A single quiet sample returns the run length to zero. The recorded condition is a sticky debug status bit that stays set until software clears it. It feeds no failsafe or clock-switching logic. The current run length is also brought out so that it can be observed.

Top module: `ool_run_monitor`

## Requirements
- R1: After reset, `ool_status` is 0 and `run_count` is 0.
- R2: With `enable` high, each clock edge that samples `corr_flag` high raises `run_count` by exactly one, unless the counter is already at its maximum.
- R3: With `enable` high, a clock edge that samples `corr_flag` low sets `run_count` to 0, so an active run that is broken must start again from one.
- R4: The status is set on the edge where the run length becomes strictly greater than `threshold` (8 bits, unsigned). With threshold T, `ool_status` is still 0 after T consecutive active samples and is 1 after T+1.
- R5: A `threshold` of 0 sets `ool_status` on the first active sample.
- R6: Once set, `ool_status` stays 1 after the run ends, for as long as `status_clr` stays low.
- R7: A `status_clr` high on an edge with no detection makes `ool_status` 0 after that edge.
- R8: If `status_clr` and a detection fall on the same edge, the detection wins and `ool_status` stays 1.
- R9: `run_count` is 9 bits wide and saturates at 511 instead of wrapping.
- R10: With `enable` low, `run_count` is held at 0 and no detection takes place. `status_clr` still acts as it does in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Monitoring enable |
| corr_flag | input | 1 | PLL correction flag, high while the PLL is correcting |
| threshold | input | 8 | Allowed run length; a longer run is flagged |
| status_clr | input | 1 | Clear strobe for the sticky status |
| ool_status | output | 1 | Sticky out-of-lock debug status |
| run_count | output | 9 | Current run length of consecutive active samples |

## Verification
There are two state registers, and each shows at the ports one edge after it goes wrong. A wrong run counter shows up directly on `run_count`. It also moves the edge where `ool_status` rises. The stimulus therefore checks the counter at threshold and threshold plus one, and after a single quiet sample. A wrong clear or detect priority shows up at once on `ool_status` when a clear is sent during a long run. Wrap-around of the counter would only appear after 511 active samples, so one long run is driven to reach that point.

// File: rtl/ool_pkg.sv
package ool_pkg;

    parameter int OOL_THR_W = 8;

    typedef enum logic [1:0] {
        SMP_OFF    = 2'd0,
        SMP_QUIET  = 2'd1,
        SMP_ACTIVE = 2'd2
    } sample_kind_e;

endpackage

// File: rtl/ool_run_counter.sv
module ool_run_counter
    import ool_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sample_kind_e     kind,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (kind)
            SMP_ACTIVE: begin
                if (state_q.run != CNT_MAX) begin
                    state_d.run = state_q.run + 1'b1;
                end
            end
            default: state_d.run = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_next = state_d.run;
    assign cnt      = state_q.run;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SMP_ACTIVE && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    p_quiet_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SMP_QUIET) |=> (cnt == '0));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SMP_ACTIVE && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SMP_OFF) |=> (cnt == '0));

endmodule

// File: rtl/ool_sticky_flag.sv
module ool_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic detect,
    input  logic clear,
    output logic flag
);
    typedef struct packed {
        logic hit;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (detect) begin
            state_d.hit = 1'b1;
        end else if (clear) begin
            state_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag = state_q.hit;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear) |=> flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !detect) |=> !flag);

    p_detect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> flag);

endmodule

// File: rtl/ool_run_monitor.sv
module ool_run_monitor
    import ool_pkg::*;
#(
    parameter int THR_W = OOL_THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             corr_flag,
    input  logic [THR_W-1:0] threshold,
    input  logic             status_clr,
    output logic             ool_status,
    output logic [THR_W:0]   run_count
);
    localparam int CNT_W = THR_W + 1;

    typedef struct packed {
        sample_kind_e kind;
        logic         detect;
    } mon_comb_t;

    mon_comb_t        mon_d;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        mon_d.kind = !enable   ? SMP_OFF :
                     corr_flag ? SMP_ACTIVE : SMP_QUIET;
        mon_d.detect = (mon_d.kind == SMP_ACTIVE) &&
                       (cnt_next > {1'b0, threshold});
    end

    ool_run_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (mon_d.kind),
        .cnt_next (cnt_next),
        .cnt      (cnt_q)
    );

    ool_sticky_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .detect (mon_d.detect),
        .clear  (status_clr),
        .flag   (ool_status)
    );

    assign run_count = cnt_q;

    p_rise_needs_long_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ool_status) |-> (run_count > {1'b0, $past(threshold)}));

    p_off_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !ool_status) |=> !ool_status);

endmodule

// File: tb/test_ool_run_monitor.sv
module test_ool_run_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       corr_flag = 1'b0;
    logic [7:0] threshold = 8'd0;
    logic       status_clr = 1'b0;
    logic       ool_status;
    logic [8:0] run_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ool_run_monitor i_ool_run_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .corr_flag  (corr_flag),
        .threshold  (threshold),
        .status_clr (status_clr),
        .ool_status (ool_status),
        .run_count  (run_count)
    );

    // vector: {enable, corr_flag, status_clr, threshold, exp_count, exp_status}
    localparam int NV = 19;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd1, 1'b0},  // R2
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd2, 1'b0},  // R2
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd3, 1'b0},  // R4 at threshold
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd4, 1'b1},  // R4 above threshold
        {1'b1, 1'b0, 1'b0, 8'd3, 9'd0, 1'b1},  // R3, R6
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd1, 1'b1},  // R6
        {1'b1, 1'b0, 1'b1, 8'd3, 9'd0, 1'b0},  // R7
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd2, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'd3, 9'd0, 1'b0},  // R3 broken run
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd2, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd3, 9'd3, 1'b0},  // R3: the run restarted
        {1'b1, 1'b1, 1'b1, 8'd3, 9'd4, 1'b1},  // R8
        {1'b1, 1'b1, 1'b1, 8'd3, 9'd5, 1'b1},  // R8
        {1'b0, 1'b1, 1'b0, 8'd3, 9'd0, 1'b1},  // R10
        {1'b0, 1'b1, 1'b1, 8'd3, 9'd0, 1'b0},  // R10 clear while disabled
        {1'b1, 1'b1, 1'b0, 8'd0, 9'd1, 1'b1},  // R5
        {1'b1, 1'b0, 1'b1, 8'd0, 9'd0, 1'b0}   // R7
    };

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic step(input logic e, input logic f, input logic c, input logic [7:0] t);
        enable = e; corr_flag = f; status_clr = c; threshold = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count", run_count, 0);
        check("R1 status", ool_status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:10]);
            check($sformatf("R2-10 vec%0d count", i), run_count, int'(VEC[i][9:1]));
            check($sformatf("R4-8 vec%0d status", i), ool_status, int'(VEC[i][0]));
        end

        // R4 at the top of the threshold range, then R9 saturation
        step(1'b1, 1'b0, 1'b1, 8'd255);
        for (int i = 0; i < 255; i++) step(1'b1, 1'b1, 1'b0, 8'd255);
        check("R4 count 255", run_count, 255);
        check("R4 status at threshold 255", ool_status, 0);
        step(1'b1, 1'b1, 1'b0, 8'd255);
        check("R4 status above threshold 255", ool_status, 1);
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0, 8'd255);
        check("R9 saturated count", run_count, 511);
        step(1'b1, 1'b1, 1'b0, 8'd255);
        check("R9 no wrap", run_count, 511);
        step(1'b1, 1'b0, 1'b0, 8'd255);
        check("R3 after saturation", run_count, 0);
        check("R6 held", ool_status, 1);

        // R1 reset in mid-operation
        step(1'b1, 1'b1, 1'b0, 8'd255);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 count after reset", run_count, 0);
        check("R1 status after reset", ool_status, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule